// File: doc/BRIEF.md
# Shared Multi-Transition Delay-Line TDC Encoder

This block is the digital back end of a multi-channel delay-line time-to-digital converter. Each channel delivers a tap snapshot that a fast-clock register array has already sampled. When a snapshot is not all zero, the fast domain takes it as a hit. It holds the snapshot together with a fast tick stamp and then hands the pair to the slow domain through a toggle handshake. The fast clock runs at exactly four times the slow clock and drives only this capture and hold logic.

In the slow domain, a round-robin arbiter lends a single encoder to one waiting channel per slow cycle. Sharing the encoder is safe because hits on the same channel are spaced far apart compared with the encoding time. The encoder finds every rising and falling edge between adjacent taps. It adds the positions of up to K of them into one fine code, which is finer than a single tap. It emits a record holding the channel index, the coarse time, the fine sum, the transition count and an overflow flag.

Top module: `tdc_mt_encoder`

## Requirements
- R1: From reset until the first nonzero snapshot reaches the block, out_valid stays low and no record is produced.
- R2: A channel's snapshot counts as a hit when any of its W bits is 1 at a rising fast edge. The record's out_coarse equals the number of fast edges between reset release and that sampling edge, not counting the sampling edge itself, modulo 2^CW. The first fast edge after release therefore stamps 0. The upper bits hold the slow cycle count and the two low bits hold the fast phase 0..3.
- R3: Once a channel has captured a hit, it ignores every further nonzero snapshot until the encoder has taken its record and the acknowledgement has come back to the fast domain. After that, the next nonzero snapshot is accepted.
- R4: A transition sits at position i (1 <= i <= W-1) when tap i differs from tap i-1, in either polarity. out_fine is the sum of the positions of the lowest K transitions and out_count is how many were summed. A snapshot with no transition, such as all ones, gives 0 and 0.
- R5: When a snapshot holds more than K transitions, out_count is K, out_fine sums only the K lowest positions and out_ovf is 1. Otherwise out_ovf is 0.
- R6: Bubbles are not filtered. A lone 1 at tap j (1 <= j <= W-2) among zeros, or a lone 0 inside a run of ones, counts as two transitions at j and j+1.
- R7: At most one channel is granted per slow cycle, and only a waiting channel. A grant is made in every cycle in which a channel is waiting. After channel c is served, the search starts at c+1 mod N. When all channels are waiting together, their records come out in consecutive slow cycles with the index rising by one mod N.
- R8: Every accepted hit produces exactly one record carrying its own channel index, even when all N channels hit on the same fast edge.
- R9: A record is a one-cycle out_valid pulse that appears on the second slow edge after the cycle in which its channel is granted. A lone hit is reported within 7 slow cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Fast capture clock, four times clk_s and edge aligned |
| clk_s | input | 1 | Slow encoding clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| snap_i | input | N*W | Tap snapshots, channel c in bits [c*W +: W], fast domain |
| out_valid | output | 1 | One-cycle record strobe, slow domain |
| out_chan | output | $clog2(N) | Channel index of the record |
| out_coarse | output | CW | Fast tick stamp of the hit (slow count x 4 + phase) |
| out_fine | output | $clog2(W*K) | Sum of the summed transition positions |
| out_count | output | $clog2(K+1) | Number of transitions summed |
| out_ovf | output | 1 | More than K transitions were present |

## Verification
The bench sweeps every single run of ones over the snapshot. It also sweeps lone bits and lone holes at every tap, tests exactly K and K+1 transitions, and mixes random multi-edge patterns fired at staggered fast phases. An encoder that ignored falling edges, stopped at the first edge or filtered bubbles would give wrong fine sums and counts. A wrong phase stamp would shift out_coarse. Two checks target the shared path: second snapshots are driven into a busy channel, and all channels are fired on the same fast edge. A missing busy guard would produce a second or corrupted record, and a broken arbiter or handshake would drop a record or break the rotating order.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // Fast clock edges per slow clock edge; the two low stamp bits are the phase.
    localparam int unsigned FAST_PER_SLOW = 4;

    // Next index in a ring of n entries.
    function automatic int wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/tdc_capture.sv
module tdc_capture #(
    parameter int W  = 64,
    parameter int CW = 16
) (
    input  logic          clk_f,
    input  logic          rst_n,
    input  logic [W-1:0]  snap_i,
    input  logic [CW-1:0] tck_i,
    input  logic          ack_tgl_i,
    output logic          req_tgl_o,
    output logic          busy_o,
    output logic [W-1:0]  held_snap_o,
    output logic [CW-1:0] held_time_o
);

    typedef struct packed {
        logic          req;
        logic          ack1;
        logic          ack2;
        logic [W-1:0]  snap;
        logic [CW-1:0] tstamp;
    } cap_t;

    cap_t cap_q, cap_d;

    always_comb begin
        cap_d      = cap_q;
        cap_d.ack1 = ack_tgl_i;
        cap_d.ack2 = cap_q.ack1;
        // Accept only while the previous request has been acknowledged.
        if ((cap_q.req == cap_q.ack2) && (snap_i != '0)) begin
            cap_d.req    = ~cap_q.req;
            cap_d.snap   = snap_i;
            cap_d.tstamp = tck_i;
        end
    end

    always_ff @(posedge clk_f or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign req_tgl_o   = cap_q.req;
    assign busy_o      = cap_q.req ^ cap_q.ack2;
    assign held_snap_o = cap_q.snap;
    assign held_time_o = cap_q.tstamp;

endmodule

// File: rtl/tdc_rr_arb.sv
module tdc_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk_s,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_i,
    output logic [N-1:0]         gnt_o,
    output logic [$clog2(N)-1:0] gnt_idx_o,
    output logic                 gnt_any_o
);

    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_t;

    arb_t arb_q, arb_d;

    always_comb begin
        arb_d     = arb_q;
        gnt_o     = '0;
        gnt_idx_o = '0;
        gnt_any_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(arb_q.ptr) + i) % N;
            if (!gnt_any_o && req_i[j]) begin
                gnt_any_o = 1'b1;
                gnt_o[j]  = 1'b1;
                gnt_idx_o = IW'(j);
                arb_d.ptr = IW'(tdc_pkg::wrap_inc(j, N));
            end
        end
    end

    always_ff @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

endmodule

// File: rtl/tdc_edge_sum.sv
module tdc_edge_sum #(
    parameter int W = 64,
    parameter int K = 4
) (
    input  logic [W-1:0]           snap_i,
    output logic [$clog2(W*K)-1:0] sum_o,
    output logic [$clog2(K+1)-1:0] cnt_o,
    output logic                   ovf_o
);

    localparam int SW  = $clog2(W*K);
    localparam int CNW = $clog2(K+1);

    always_comb begin
        int   acc;
        int   num;
        logic over;
        acc  = 0;
        num  = 0;
        over = 1'b0;
        for (int i = 1; i < W; i++) begin
            if (snap_i[i] != snap_i[i-1]) begin
                if (num < K) begin
                    acc = acc + i;
                    num = num + 1;
                end else begin
                    over = 1'b1;
                end
            end
        end
        sum_o = SW'(acc);
        cnt_o = CNW'(num);
        ovf_o = over;
    end

endmodule

// File: rtl/tdc_mt_encoder.sv
module tdc_mt_encoder #(
    parameter int N  = 4,
    parameter int W  = 64,
    parameter int K  = 4,
    parameter int CW = 16
) (
    input  logic                   clk_f,
    input  logic                   clk_s,
    input  logic                   rst_n,
    input  logic [N*W-1:0]         snap_i,
    output logic                   out_valid,
    output logic [$clog2(N)-1:0]   out_chan,
    output logic [CW-1:0]          out_coarse,
    output logic [$clog2(W*K)-1:0] out_fine,
    output logic [$clog2(K+1)-1:0] out_count,
    output logic                   out_ovf
);

    localparam int CHW = $clog2(N);
    localparam int SW  = $clog2(W*K);
    localparam int CNW = $clog2(K+1);

    // ---------------- fast domain: tick counter ----------------
    typedef struct packed {
        logic [CW-1:0] tck;
    } fst_t;

    fst_t fst_q, fst_d;

    always_comb begin
        fst_d     = fst_q;
        fst_d.tck = fst_q.tck + 1'b1;
    end

    always_ff @(posedge clk_f or negedge rst_n) begin
        if (!rst_n) fst_q <= '0;
        else        fst_q <= fst_d;
    end

    // ---------------- fast domain: per-channel capture ----------------
    logic [N-1:0]  req_tgl;
    logic [N-1:0]  busy;
    logic [N-1:0]  ack_tgl;
    logic [W-1:0]  held_snap [N];
    logic [CW-1:0] held_time [N];

    for (genvar ch = 0; ch < N; ch++) begin : g_cap
        tdc_capture #(.W(W), .CW(CW)) u_cap (
            .clk_f       (clk_f),
            .rst_n       (rst_n),
            .snap_i      (snap_i[ch*W +: W]),
            .tck_i       (fst_q.tck),
            .ack_tgl_i   (ack_tgl[ch]),
            .req_tgl_o   (req_tgl[ch]),
            .busy_o      (busy[ch]),
            .held_snap_o (held_snap[ch]),
            .held_time_o (held_time[ch])
        );
    end

    // ---------------- slow domain ----------------
    typedef struct packed {
        logic [N-1:0]   rs1;
        logic [N-1:0]   rs2;
        logic [N-1:0]   ack;
        logic           s1_vld;
        logic [CHW-1:0] s1_chan;
        logic [W-1:0]   s1_snap;
        logic [CW-1:0]  s1_time;
        logic           o_vld;
        logic [CHW-1:0] o_chan;
        logic [CW-1:0]  o_time;
        logic [SW-1:0]  o_sum;
        logic [CNW-1:0] o_cnt;
        logic           o_ovf;
    } slw_t;

    slw_t slw_q, slw_d;

    logic [N-1:0]   pend;
    logic [N-1:0]   gnt;
    logic [CHW-1:0] gnt_idx;
    logic           gnt_any;
    logic [SW-1:0]  es_sum;
    logic [CNW-1:0] es_cnt;
    logic           es_ovf;

    assign pend    = slw_q.rs2 ^ slw_q.ack;
    assign ack_tgl = slw_q.ack;

    tdc_rr_arb #(.N(N)) u_arb (
        .clk_s     (clk_s),
        .rst_n     (rst_n),
        .req_i     (pend),
        .gnt_o     (gnt),
        .gnt_idx_o (gnt_idx),
        .gnt_any_o (gnt_any)
    );

    tdc_edge_sum #(.W(W), .K(K)) u_enc (
        .snap_i (slw_q.s1_snap),
        .sum_o  (es_sum),
        .cnt_o  (es_cnt),
        .ovf_o  (es_ovf)
    );

    always_comb begin
        slw_d        = slw_q;
        slw_d.rs1    = req_tgl;
        slw_d.rs2    = slw_q.rs1;
        slw_d.ack    = slw_q.ack ^ gnt;
        slw_d.s1_vld = gnt_any;
        if (gnt_any) begin
            slw_d.s1_chan = gnt_idx;
            slw_d.s1_snap = held_snap[gnt_idx];
            slw_d.s1_time = held_time[gnt_idx];
        end
        slw_d.o_vld = slw_q.s1_vld;
        if (slw_q.s1_vld) begin
            slw_d.o_chan = slw_q.s1_chan;
            slw_d.o_time = slw_q.s1_time;
            slw_d.o_sum  = es_sum;
            slw_d.o_cnt  = es_cnt;
            slw_d.o_ovf  = es_ovf;
        end
    end

    always_ff @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) slw_q <= '0;
        else        slw_q <= slw_d;
    end

    assign out_valid  = slw_q.o_vld;
    assign out_chan   = slw_q.o_chan;
    assign out_coarse = slw_q.o_time;
    assign out_fine   = slw_q.o_sum;
    assign out_count  = slw_q.o_cnt;
    assign out_ovf    = slw_q.o_ovf;

endmodule

// File: rtl/tdc_mt_encoder_chk.sv
module tdc_mt_encoder_chk #(
    parameter int N  = 4,
    parameter int W  = 64,
    parameter int K  = 4,
    parameter int CW = 16
) (
    input logic                   clk_f,
    input logic                   clk_s,
    input logic                   rst_n,
    input logic [N-1:0]           busy,
    input logic [W-1:0]           held_snap [N],
    input logic [CW-1:0]          held_time [N],
    input logic [N-1:0]           pend,
    input logic [N-1:0]           gnt,
    input logic                   gnt_any,
    input logic                   out_valid,
    input logic [$clog2(K+1)-1:0] out_count,
    input logic                   out_ovf,
    input logic [$clog2(W*K)-1:0] out_fine
);

    // R7: a single grant per slow cycle
    a_r7_one_grant: assert property (@(posedge clk_s) disable iff (!rst_n)
        $onehot0(gnt));

    // R7: only waiting channels are granted
    a_r7_grant_pending: assert property (@(posedge clk_s) disable iff (!rst_n)
        (gnt & ~pend) == '0);

    // R7: the encoder never idles while a channel waits
    a_r7_no_idle: assert property (@(posedge clk_s) disable iff (!rst_n)
        (|pend) |-> gnt_any);

    // R9: the record follows the grant on the second slow edge
    a_r9_latency: assert property (@(posedge clk_s) disable iff (!rst_n)
        gnt_any |=> ##1 out_valid);

    // R9: no record without a grant two cycles earlier
    a_r9_no_spurious: assert property (@(posedge clk_s) disable iff (!rst_n)
        out_valid |-> $past(gnt_any, 2));

    // R4: the count never exceeds K
    a_r4_count_cap: assert property (@(posedge clk_s) disable iff (!rst_n)
        out_valid |-> (int'(out_count) <= K));

    // R4: no transitions means a zero fine sum
    a_r4_zero_sum: assert property (@(posedge clk_s) disable iff (!rst_n)
        (out_valid && out_count == '0) |-> (out_fine == '0));

    // R5: overflow only with a full count
    a_r5_ovf_full: assert property (@(posedge clk_s) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (int'(out_count) == K));

    // R3: held data stays put while the channel is busy
    for (genvar i = 0; i < N; i++) begin : g_hold
        a_r3_hold_stable: assert property (@(posedge clk_f) disable iff (!rst_n)
            (busy[i] && $past(busy[i])) |->
            ($stable(held_snap[i]) && $stable(held_time[i])));
    end

endmodule

bind tdc_mt_encoder tdc_mt_encoder_chk #(.N(N), .W(W), .K(K), .CW(CW)) u_chk (
    .clk_f     (clk_f),
    .clk_s     (clk_s),
    .rst_n     (rst_n),
    .busy      (busy),
    .held_snap (held_snap),
    .held_time (held_time),
    .pend      (pend),
    .gnt       (gnt),
    .gnt_any   (gnt_any),
    .out_valid (out_valid),
    .out_count (out_count),
    .out_ovf   (out_ovf),
    .out_fine  (out_fine)
);

// File: tb/tb_tdc_mt_encoder.sv
`timescale 1ns/1ps
module tb_tdc_mt_encoder;

    localparam int N   = 4;
    localparam int W   = 64;
    localparam int K   = 4;
    localparam int CW  = 16;
    localparam int SW  = $clog2(W*K);
    localparam int CNW = $clog2(K+1);

    logic           clk_f = 1'b0;
    logic           clk_s = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] snap  = '0;
    logic           out_valid;
    logic [1:0]     out_chan;
    logic [CW-1:0]  out_coarse;
    logic [SW-1:0]  out_fine;
    logic [CNW-1:0] out_count;
    logic           out_ovf;

    tdc_mt_encoder #(.N(N), .W(W), .K(K), .CW(CW)) dut (
        .clk_f      (clk_f),
        .clk_s      (clk_s),
        .rst_n      (rst_n),
        .snap_i     (snap),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_coarse (out_coarse),
        .out_fine   (out_fine),
        .out_count  (out_count),
        .out_ovf    (out_ovf)
    );

    // 100 MHz slow clock, fast clock four times faster with aligned edges
    initial forever #1.25 clk_f = ~clk_f;
    initial begin
        #1.25;
        forever #5 clk_s = ~clk_s;
    end

    int nchk = 0;
    int nerr = 0;
    int fedge = 0;
    int scyc = 0;
    int total_rec = 0;

    logic [CW-1:0] r_time [N];
    int            r_sum  [N];
    int            r_cnt  [N];
    bit            r_ovf  [N];
    int            r_num  [N];
    int            ord_ch [64];
    int            ord_cyc[64];
    int            nord = 0;

    logic [W-1:0]  pat    [N];
    logic [CW-1:0] e_time [N];
    bit            e_act  [N];
    int            nslot = 0;

    always @(posedge clk_f) if (rst_n) fedge = fedge + 1;

    always @(negedge clk_s) begin
        scyc = scyc + 1;
        if (rst_n && out_valid) begin
            int c;
            c = int'(out_chan);
            r_time[c] = out_coarse;
            r_sum[c]  = int'(out_fine);
            r_cnt[c]  = int'(out_count);
            r_ovf[c]  = out_ovf;
            r_num[c]  = r_num[c] + 1;
            total_rec = total_rec + 1;
            if (nord < 64) begin
                ord_ch[nord]  = c;
                ord_cyc[nord] = scyc;
                nord = nord + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string msg);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic void exp_enc(input logic [W-1:0] s, output int sm,
                                    output int cn, output bit ov);
        sm = 0; cn = 0; ov = 1'b0;
        for (int i = 1; i < W; i++) begin
            if (s[i] != s[i-1]) begin
                if (cn < K) begin sm = sm + i; cn = cn + 1; end
                else ov = 1'b1;
            end
        end
    endfunction

    function automatic logic [W-1:0] run_pat(input int a, input int b);
        logic [W-1:0] r;
        r = '0;
        for (int i = a; i <= b; i++) r[i] = 1'b1;
        return r;
    endfunction

    task automatic clear_rec();
        for (int c = 0; c < N; c++) r_num[c] = 0;
        nord = 0;
    endtask

    task automatic fire(input int c);
        @(posedge clk_f); #0.4;
        snap[c*W +: W] = pat[c];
        e_time[c] = fedge[CW-1:0];
        @(posedge clk_f); #0.4;
        snap[c*W +: W] = '0;
    endtask

    task automatic fire_all();
        @(posedge clk_f); #0.4;
        for (int c = 0; c < N; c++) begin
            if (e_act[c]) begin
                snap[c*W +: W] = pat[c];
                e_time[c] = fedge[CW-1:0];
            end
        end
        @(posedge clk_f); #0.4;
        snap = '0;
    endtask

    task automatic check_round(input string tag);
        repeat (16) @(negedge clk_s);
        #1;
        for (int c = 0; c < N; c++) begin
            int sm, cn;
            bit ov;
            if (e_act[c]) begin
                exp_enc(pat[c], sm, cn, ov);
                chk(r_num[c] == 1, $sformatf("R8 ch%0d records act %0d exp 1", c, r_num[c]));
                chk(r_num[c] == 1 && r_sum[c] == sm && r_cnt[c] == cn && r_ovf[c] == ov
                    && r_time[c] == e_time[c],
                    $sformatf("%s/R2 ch%0d pat %h act fine %0d cnt %0d ovf %0d coarse %0d exp fine %0d cnt %0d ovf %0d coarse %0d",
                              tag, c, pat[c], r_sum[c], r_cnt[c], r_ovf[c], r_time[c],
                              sm, cn, ov, e_time[c]));
            end else begin
                chk(r_num[c] == 0, $sformatf("R8 idle ch%0d records act %0d exp 0", c, r_num[c]));
            end
        end
    endtask

    task automatic run_round(input string tag, input bit stagger);
        clear_rec();
        repeat ($urandom_range(0, 3)) @(posedge clk_f);
        if (stagger) begin
            for (int c = 0; c < N; c++) if (e_act[c]) fire(c);
        end else begin
            fire_all();
        end
        check_round(tag);
        for (int c = 0; c < N; c++) e_act[c] = 1'b0;
        nslot = 0;
    endtask

    task automatic push(input logic [W-1:0] s, input string tag, input bit stagger);
        pat[nslot]   = s;
        e_act[nslot] = 1'b1;
        nslot = nslot + 1;
        if (nslot == N) run_round(tag, stagger);
    endtask

    task automatic flush(input string tag);
        if (nslot != 0) run_round(tag, 1'b1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    endtask

    initial begin
        #1_900_000;
        nerr = nerr + 1;
        $display("FAIL R8 watchdog: run still active at timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] s;
        int s0;
        for (int c = 0; c < N; c++) begin
            e_act[c] = 1'b0; r_num[c] = 0; pat[c] = '0; e_time[c] = '0;
        end

        // R1: reset state
        #20;
        chk(out_valid == 1'b0, $sformatf("R1 out_valid in reset act %0b exp 0", out_valid));
        #20.3 rst_n = 1'b1;
        repeat (10) @(negedge clk_s);
        #1;
        chk(out_valid == 1'b0 && total_rec == 0,
            $sformatf("R1 idle records act %0d exp 0", total_rec));

        // R9: lone hit latency
        clear_rec();
        pat[1] = run_pat(5, 20); e_act[1] = 1'b1;
        s0 = scyc;
        fire(1);
        check_round("R9/R4");
        chk(nord == 1 && (ord_cyc[0] - s0) >= 3 && (ord_cyc[0] - s0) <= 7,
            $sformatf("R9 latency act %0d exp 3..7", ord_cyc[0] - s0));
        e_act[1] = 1'b0;

        // R3: second snapshots into a busy channel are ignored
        clear_rec();
        pat[0] = run_pat(2, 9); e_act[0] = 1'b1;
        @(posedge clk_f); #0.4;
        snap[0 +: W] = pat[0];
        e_time[0] = fedge[CW-1:0];
        @(posedge clk_f); #0.4;
        snap[0 +: W] = run_pat(30, 40);
        @(posedge clk_f); #0.4;
        snap[0 +: W] = {W{1'b1}} ^ 64'h5;
        @(posedge clk_f); #0.4;
        snap[0 +: W] = '0;
        check_round("R3/R4");
        chk(r_num[0] == 1, $sformatf("R3 busy channel records act %0d exp 1", r_num[0]));
        e_act[0] = 1'b0;
        // R3: accepted again after the handshake returns
        pat[0] = run_pat(44, 50); e_act[0] = 1'b1;
        run_round("R3", 1'b1);

        // R7/R8: all channels on the same fast edge, twice
        for (int rep = 0; rep < 2; rep++) begin
            for (int c = 0; c < N; c++) begin
                pat[c] = run_pat(c * 3 + rep, c * 7 + 20); e_act[c] = 1'b1;
            end
            clear_rec();
            fire_all();
            check_round("R8/R4");
            chk(nord == N, $sformatf("R7 record total act %0d exp %0d", nord, N));
            for (int i = 1; i < N && i < nord; i++) begin
                chk(ord_ch[i] == (ord_ch[0] + i) % N && ord_cyc[i] == ord_cyc[0] + i,
                    $sformatf("R7 order slot %0d act ch%0d cyc+%0d exp ch%0d cyc+%0d",
                              i, ord_ch[i], ord_cyc[i] - ord_cyc[0], (ord_ch[0] + i) % N, i));
            end
            for (int c = 0; c < N; c++) e_act[c] = 1'b0;
        end

        // R4: all ones has no transition
        pat[2] = '1; e_act[2] = 1'b1;
        run_round("R4", 1'b1);

        // R5: exactly K, then K+1 transitions
        push(run_pat(3, 5) | run_pat(10, 20), "R5", 1'b1);
        push(run_pat(3, 5) | run_pat(10, 20) | run_pat(30, 30), "R5", 1'b1);
        push(run_pat(1, 1) | run_pat(3, 3), "R5", 1'b1);
        push(run_pat(1, 1) | run_pat(3, 3) | run_pat(62, 63), "R5", 1'b1);

        // R4: every single run of ones
        for (int a = 0; a < W; a++)
            for (int b = a; b < W; b++)
                push(run_pat(a, b), "R4", (a % 2) == 1);
        flush("R4");

        // R6: lone bits and lone holes at every tap
        for (int j = 0; j < W; j++) begin
            s = '0; s[j] = 1'b1;
            push(s, "R6/R4", 1'b1);
        end
        for (int j = 1; j < 50; j++) begin
            s = run_pat(0, 50); s[j] = 1'b0;
            push(s, "R6", 1'b0);
        end
        flush("R6");

        // R5: random multi-edge patterns at random phases
        for (int t = 0; t < 400; t++) begin
            int nt;
            s = '0;
            nt = $urandom_range(0, 9);
            for (int e = 0; e < nt; e++) begin
                int p;
                p = $urandom_range(1, W - 1);
                for (int i = p; i < W; i++) s[i] = ~s[i];
            end
            if (s == '0) s[W-1] = 1'b1;
            push(s, "R5/R4", (t % 3) != 0);
        end
        flush("R5/R4");

        finish_run();
    end

endmodule